// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block collects interrupt requests for 40 lines. The lines sit in a 32-line low bank and an 8-line high bank. Sixteen external event inputs feed lines 0 to 15. Each line can latch a pending request from a selected rising or falling edge on its input, or from a software trigger. When a request is latched, the matching output gives a one-cycle pulse. Software acknowledges a request by writing a one to its pending bit.

Software reaches the block over a plain 32-bit word bus: address, write enable, write data and read data. Writes take effect at the clock edge and reads are combinational. Each bank has six registers:

| Register | Low bank | High bank |
|---|---|---|
| Line enable | 0x00 | 0x20 |
| Event enable | 0x04 | 0x24 |
| Rising select | 0x08 | 0x28 |
| Falling select | 0x0C | 0x2C |
| Software trigger | 0x10 | 0x30 |
| Pending | 0x14 | 0x34 |

The high bank uses bits 7:0 of each word for lines 32 to 39.

Some lines are fixed and cannot be configured. In the low bank these are bits 31:23 and bit 17 (0xFF820000). In the high bank they are bits 0, 1, 2 and 7 (0x87). No write can give these lines a trigger or a pending bit. The inputs are taken to be synchronous to the clock already. An edge is found by comparing each input with its value at the previous clock edge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the line-enable register reads 0xFF820000 in the low bank and 0x00000087 in the high bank. The other ten registers read zero and no output pulses.
- R2: Writes to the line-enable and event-enable registers store every line the bank has and read back unchanged. In the high bank only bits 7:0 are kept, and bits 31:8 read zero.
- R3: Writes to the rising-select, falling-select, software-trigger and pending registers ignore the fixed lines (low bank 0xFF820000, high bank 0x87). Those bits read zero, and fixed lines never pulse.
- R4: Take an enabled line (line-enable bit 1) whose input goes from 0 to 1 at one clock edge while its rising-select bit is 1, or from 1 to 0 while its falling-select bit is 1. That line sets its pending bit and pulses in the cycle after that edge. Any other combination of edge and select bits does nothing.
- R5: A line whose line-enable bit is 0 never latches or pulses from an input edge.
- R6: A software-trigger write latches and pulses a configurable line only if all of these hold: its written bit is 1, its stored trigger bit was 0, the line is enabled, and the line is not already pending. The register then holds the configurable written bits, and rewriting a 1 does not trigger again.
- R7: Writing 1 to a set, configurable pending bit clears that bit and also clears the line's software-trigger bit. Writing 0 leaves it unchanged.
- R8: Every output pulse lasts exactly one cycle. An edge and a software trigger that hit the same line in one cycle give a single pulse.
- R9: The map uses word offsets 0x00 to 0x14 for the low bank and 0x20 to 0x34 for the high bank, within a 0x400-byte window. Other offsets, and addresses with bits 1:0 not zero, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 10 | Byte address in the register window |
| busWe | input | 1 | Write strobe for the addressed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| extIn | input | 16 | External event inputs for lines 0 to 15 |
| irqPulse | output | 40 | One-cycle request pulse per line |

## Verification
The assertions assume that extIn changes only between clock edges and is already synchronous to the clock. They also assume that every bus write is a whole word presented for one clock edge. They therefore trace each output pulse to either an input change seen against the previous sample or a software-trigger write in the cycle before. The bench respects these assumptions: it drives extIn and the bus only just after a falling edge and holds them through the next rising edge. Its random part mixes writes to mapped, unmapped and misaligned addresses with random flips of the inputs.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  // Register index taken from address bits 4:2; the order fixes the map.
  typedef enum logic [2:0] {
    SEL_LINE_EN = 3'd0,
    SEL_EV_EN   = 3'd1,
    SEL_RISE    = 3'd2,
    SEL_FALL    = 3'd3,
    SEL_SWTRIG  = 3'd4,
    SEL_PEND    = 3'd5,
    SEL_NONE    = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrLineEn;
    logic    wrEvEn;
    logic    wrRise;
    logic    wrFall;
    logic    wrSwTrig;
    logic    wrPendClr;
    logic    bankHi;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/edge_irq_ctl.sv
module edge_irq_ctl
  import edge_irq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctlStrobe_t        stb
);

  localparam int BANK_BIT = 5;
  localparam int REG_LO   = 2;
  localparam int REG_HI   = 4;
  localparam int TOP_LO   = 6;
  localparam logic [2:0] LAST_REG = 3'd5;

  logic       mapped;
  logic [2:0] regIdx;

  always_comb begin
    regIdx = busAddr[REG_HI:REG_LO];
    mapped = (busAddr[1:0] == 2'b00) &&
             (busAddr[ADDR_W-1:TOP_LO] == '0) &&
             (regIdx <= LAST_REG);
  end

  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    if (mapped) begin
      stb.bankHi = busAddr[BANK_BIT];
      stb.rdSel  = regSel_e'(regIdx);
      if (busWe) begin
        unique case (regSel_e'(regIdx))
          SEL_LINE_EN: stb.wrLineEn  = 1'b1;
          SEL_EV_EN:   stb.wrEvEn    = 1'b1;
          SEL_RISE:    stb.wrRise    = 1'b1;
          SEL_FALL:    stb.wrFall    = 1'b1;
          SEL_SWTRIG:  stb.wrSwTrig  = 1'b1;
          SEL_PEND:    stb.wrPendClr = 1'b1;
          default:     ;
        endcase
      end
    end
  end

endmodule

// File: rtl/edge_irq_dp.sv
module edge_irq_dp
  import edge_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HI_LINES = 8,
  parameter int EXT_W    = 16,
  parameter logic [DATA_W+HI_LINES-1:0] FIXED = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 stb,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [EXT_W-1:0]           extIn,
  output logic [DATA_W+HI_LINES-1:0] irqPulse
);

  localparam int LINES = DATA_W + HI_LINES;
  localparam logic [LINES-1:0] LO_LANES = {{HI_LINES{1'b0}}, {DATA_W{1'b1}}};
  localparam logic [LINES-1:0] CFG      = ~FIXED;

  logic [LINES-1:0] lineEnQ, evEnQ, riseQ, fallQ, swQ, pendQ;
  logic [EXT_W-1:0] extQ;

  logic [LINES-1:0] lane, wide, wrBits, cfgBits;
  logic [LINES-1:0] extWide, prevWide, riseEdge, fallEdge;
  logic [LINES-1:0] edgeHit, swHit, clrBits, hit, swNext;
  logic [LINES-1:0] rdVec;

  // Place the bus word on the lines of the addressed bank.
  always_comb begin
    lane    = stb.bankHi ? ~LO_LANES : LO_LANES;
    wide    = stb.bankHi ? {busWdata[HI_LINES-1:0], {DATA_W{1'b0}}}
                         : {{HI_LINES{1'b0}}, busWdata};
    wrBits  = wide & lane;
    cfgBits = wrBits & CFG;
  end

  // Edge detection against the previous sample.
  always_comb begin
    extWide  = {{(LINES-EXT_W){1'b0}}, extIn};
    prevWide = {{(LINES-EXT_W){1'b0}}, extQ};
    riseEdge = extWide & ~prevWide;
    fallEdge = ~extWide & prevWide;
    edgeHit  = lineEnQ & ((riseEdge & riseQ) | (fallEdge & fallQ));
  end

  // Software trigger and acknowledge.
  always_comb begin
    swHit   = stb.wrSwTrig  ? (cfgBits & ~swQ & lineEnQ & ~pendQ) : '0;
    clrBits = stb.wrPendClr ? (pendQ & cfgBits) : '0;
    hit     = edgeHit | swHit;
    if (stb.wrSwTrig)       swNext = (swQ & ~lane) | cfgBits;
    else if (stb.wrPendClr) swNext = swQ & ~clrBits;
    else                    swNext = swQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEnQ  <= FIXED;
      evEnQ    <= '0;
      riseQ    <= '0;
      fallQ    <= '0;
      swQ      <= '0;
      pendQ    <= '0;
      extQ     <= '0;
      irqPulse <= '0;
    end else begin
      extQ     <= extIn;
      swQ      <= swNext;
      pendQ    <= (pendQ & ~clrBits) | hit;
      irqPulse <= hit;
      if (stb.wrLineEn) lineEnQ <= (lineEnQ & ~lane) | wrBits;
      if (stb.wrEvEn)   evEnQ   <= (evEnQ & ~lane) | wrBits;
      if (stb.wrRise)   riseQ   <= (riseQ & ~lane) | cfgBits;
      if (stb.wrFall)   fallQ   <= (fallQ & ~lane) | cfgBits;
    end
  end

  // Read path: pick the register, then the bank slice.
  always_comb begin
    unique case (stb.rdSel)
      SEL_LINE_EN: rdVec = lineEnQ;
      SEL_EV_EN:   rdVec = evEnQ;
      SEL_RISE:    rdVec = riseQ;
      SEL_FALL:    rdVec = fallQ;
      SEL_SWTRIG:  rdVec = swQ;
      SEL_PEND:    rdVec = pendQ;
      default:     rdVec = '0;
    endcase
    busRdata = stb.bankHi ? {{(DATA_W-HI_LINES){1'b0}}, rdVec[LINES-1:DATA_W]}
                          : rdVec[DATA_W-1:0];
  end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int HI_LINES = 8,
  parameter int EXT_W    = 16,
  parameter logic [DATA_W-1:0]   FIXED_LO = 32'hFF82_0000,
  parameter logic [HI_LINES-1:0] FIXED_HI = 8'h87
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWe,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [EXT_W-1:0]           extIn,
  output logic [DATA_W+HI_LINES-1:0] irqPulse
);

  localparam logic [DATA_W+HI_LINES-1:0] FIXED = {FIXED_HI, FIXED_LO};

  ctlStrobe_t stb;

  edge_irq_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  edge_irq_dp #(
    .DATA_W   (DATA_W),
    .HI_LINES (HI_LINES),
    .EXT_W    (EXT_W),
    .FIXED    (FIXED)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .extIn    (extIn),
    .irqPulse (irqPulse)
  );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int HI_LINES = 8,
  parameter int EXT_W    = 16,
  parameter logic [DATA_W-1:0]   FIXED_LO = 32'hFF82_0000,
  parameter logic [HI_LINES-1:0] FIXED_HI = 8'h87
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       busWe,
  input logic [DATA_W-1:0]          busWdata,
  input logic [DATA_W-1:0]          busRdata,
  input logic [EXT_W-1:0]           extIn,
  input logic [DATA_W+HI_LINES-1:0] irqPulse
);

  localparam int LINES = DATA_W + HI_LINES;
  localparam logic [LINES-1:0] FIXED = {FIXED_HI, FIXED_LO};

  logic             mapped, swWr;
  logic [EXT_W-1:0] prevIn;

  always_comb begin
    mapped = (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-1:6] == '0) &&
             (busAddr[4:2] <= 3'd5);
    swWr   = busWe && mapped && (busAddr[4:2] == 3'd4);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= extIn;
  end

  // R3: fixed lines stay silent
  a_r3_fixed_silent: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & FIXED) == '0);

  // R6: lines without an input pulse only after a software-trigger write
  a_r6_upper_needs_sw: assert property (@(posedge clk) disable iff (!rstN)
    (|irqPulse[LINES-1:EXT_W]) |-> $past(swWr));

  // R9: unmapped addresses read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (busRdata == '0));

  // R2: high bank upper bits read zero
  a_r2_hi_bank_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (mapped && busAddr[5]) |-> (busRdata[DATA_W-1:HI_LINES] == '0));

  // R4: each input-line pulse has an input change or a trigger write behind it
  for (genvar i = 0; i < EXT_W; i++) begin : g_cause
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[i] |-> ($past(extIn[i]) != $past(prevIn[i])) || $past(swWr));
  end

endmodule

bind edge_irq_ctrl edge_irq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .HI_LINES (HI_LINES),
  .EXT_W    (EXT_W),
  .FIXED_LO (FIXED_LO),
  .FIXED_HI (FIXED_HI)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .extIn    (extIn),
  .irqPulse (irqPulse)
);

// File: tb/edge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb_top;

  localparam logic [39:0] FIXED = 40'h87_FF82_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] extIn = '0;
  logic [39:0] irqPulse;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  logic [39:0] mLineEn, mEvEn, mRise, mFall, mSw, mPend;
  logic [15:0] mPrev;

  always #10 clk = ~clk;

  edge_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .extIn(extIn), .irqPulse(irqPulse)
  );

  function automatic bit isMapped(input logic [9:0] a);
    return (a[1:0] == 0) && (a[9:6] == 0) && (a[4:2] <= 5);
  endfunction

  function automatic logic [31:0] modelRead(input logic [9:0] a);
    logic [39:0] v;
    if (!isMapped(a)) return 32'h0;
    case (a[4:2])
      3'd0: v = mLineEn;
      3'd1: v = mEvEn;
      3'd2: v = mRise;
      3'd3: v = mFall;
      3'd4: v = mSw;
      default: v = mPend;
    endcase
    return a[5] ? {24'h0, v[39:32]} : v[31:0];
  endfunction

  task automatic check40(input logic [39:0] act, input logic [39:0] exp, input string tag);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readLit(input logic [9:0] a, input logic [31:0] exp, input string tag);
    busWe = 0; busAddr = a; #2;
    check40({8'h0, busRdata}, {8'h0, exp}, tag);
  endtask

  task automatic readChk(input logic [9:0] a, input string tag);
    readLit(a, modelRead(a), tag);
  endtask

  // One clock: drive at negedge, update model, check pulses at next negedge.
  task automatic step(input logic we, input logic [9:0] a, input logic [31:0] d,
                      input logic [15:0] ext, input string tag);
    logic [39:0] expHit, nEn, nEv, nRise, nFall, nSw, nPend;
    bit mp, hiB, inB, db, cfg, re, fe;
    int bp;
    mp = isMapped(a) && we;
    hiB = a[5];
    expHit = '0;
    nEn = mLineEn; nEv = mEvEn; nRise = mRise; nFall = mFall; nSw = mSw; nPend = mPend;
    for (int i = 0; i < 40; i++) begin
      inB = hiB ? (i >= 32) : (i < 32);
      bp  = (i < 32) ? i : i - 32;
      db  = d[bp];
      cfg = !FIXED[i];
      re = (i < 16) ? (ext[i] && !mPrev[i]) : 0;
      fe = (i < 16) ? (!ext[i] && mPrev[i]) : 0;
      if (mLineEn[i] && ((re && mRise[i]) || (fe && mFall[i]))) expHit[i] = 1;
      if (mp && inB) begin
        case (a[4:2])
          3'd0: nEn[i] = db;
          3'd1: nEv[i] = db;
          3'd2: nRise[i] = cfg && db;
          3'd3: nFall[i] = cfg && db;
          3'd4: begin
            if (cfg && db && !mSw[i] && mLineEn[i] && !mPend[i]) expHit[i] = 1;
            nSw[i] = cfg && db;
          end
          3'd5: if (cfg && db && mPend[i]) begin nPend[i] = 0; nSw[i] = 0; end
          default: ;
        endcase
      end
      if (expHit[i]) nPend[i] = 1;
    end
    busWe = we; busAddr = a; busWdata = d; extIn = ext;
    @(posedge clk);
    mLineEn = nEn; mEvEn = nEv; mRise = nRise; mFall = nFall; mSw = nSw; mPend = nPend;
    mPrev = ext;
    @(negedge clk);
    busWe = 0;
    check40(irqPulse, expHit, tag);
  endtask

  task automatic readAll(input string tag);
    for (int r = 0; r < 6; r++) begin
      readChk(10'(r * 4), tag);
      readChk(10'(32 + r * 4), tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    mLineEn = FIXED; mEvEn = 0; mRise = 0; mFall = 0; mSw = 0; mPend = 0; mPrev = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset values
    readLit(10'h00, 32'hFF82_0000, "R1 low line enable");
    readLit(10'h20, 32'h0000_0087, "R1 high line enable");
    readAll("R1 reset registers");
    check40(irqPulse, 40'h0, "R1 no pulse after reset");

    // R2: enable registers keep valid bits
    step(1, 10'h24, 32'hFFFF_FFFF, 16'h0, "R2 event enable high write");
    readLit(10'h24, 32'h0000_00FF, "R2 high bank event enable 7:0");
    step(1, 10'h04, 32'hDEAD_BEEF, 16'h0, "R2 event enable low write");
    readLit(10'h04, 32'hDEAD_BEEF, "R2 low event enable");

    // R3: fixed lines ignored in trigger selects
    step(1, 10'h08, 32'hFFFF_FFFF, 16'h0, "R3 rise all");
    readLit(10'h08, 32'h007D_FFFF, "R3 rise low ignores fixed");
    step(1, 10'h28, 32'hFFFF_FFFF, 16'h0, "R3 rise high");
    readLit(10'h28, 32'h0000_0078, "R3 rise high ignores fixed");

    // R5: lines 0..15 still disabled, edge does nothing
    step(0, 10'h0, 32'h0, 16'h0001, "R5 masked rising edge no pulse");
    readLit(10'h14, 32'h0, "R5 no pending from masked line");

    // R4: edges
    step(1, 10'h00, 32'hFFFF_FFFF, 16'h0001, "R2 line enable low");
    step(1, 10'h08, 32'h0000_0001, 16'h0000, "R4 rise on line 0");
    step(1, 10'h0C, 32'h0000_0002, 16'h0000, "R4 fall on line 1");
    step(0, 10'h0, 32'h0, 16'h0001, "R4 rising edge line 0 pulses");
    step(0, 10'h0, 32'h0, 16'h0003, "R4 rising edge line 1 ignored");
    step(0, 10'h0, 32'h0, 16'h0000, "R4 falling edge line 1 pulses");
    readLit(10'h14, 32'h0000_0003, "R4 pending lines 0 and 1");

    // R7: acknowledge
    step(1, 10'h14, 32'h0000_0001, 16'h0, "R7 clear line 0");
    readLit(10'h14, 32'h0000_0002, "R7 line 1 stays pending");
    step(1, 10'h14, 32'hFFFF_FFFF, 16'h0, "R7 clear all");
    readLit(10'h14, 32'h0, "R7 pending empty");

    // R6: software trigger
    step(1, 10'h10, 32'h0000_0100, 16'h0, "R6 trigger line 8");
    step(1, 10'h10, 32'h0000_0100, 16'h0, "R6 repeat trigger no pulse");
    readLit(10'h10, 32'h0000_0100, "R6 trigger register holds");
    step(1, 10'h14, 32'h0000_0100, 16'h0, "R7 clear line 8");
    readLit(10'h10, 32'h0, "R7 trigger bit cleared with pending");
    step(1, 10'h10, 32'hFF82_0000, 16'h0, "R3 trigger fixed lines no pulse");
    readLit(10'h10, 32'h0, "R3 trigger fixed lines read zero");
    step(1, 10'h30, 32'h0000_0078, 16'h0, "R6 high trigger while disabled");
    readLit(10'h34, 32'h0, "R6 disabled lines not pending");
    step(1, 10'h20, 32'h0000_00FF, 16'h0, "R2 high line enable");
    step(1, 10'h30, 32'h0000_0000, 16'h0, "R6 high trigger reset");
    step(1, 10'h30, 32'h0000_0008, 16'h0, "R6 trigger line 35");

    // R8: edge and trigger together give one pulse
    step(1, 10'h08, 32'h0000_0004, 16'h0, "R8 rise on line 2");
    step(1, 10'h10, 32'h0000_0004, 16'h0004, "R8 edge plus trigger single pulse");
    step(0, 10'h0, 32'h0, 16'h0004, "R8 pulse lasts one cycle");

    // R9: unmapped accesses
    step(1, 10'h18, 32'hFFFF_FFFF, 16'h0004, "R9 write 0x18");
    step(1, 10'h3C, 32'hFFFF_FFFF, 16'h0004, "R9 write 0x3C");
    step(1, 10'h101, 32'hFFFF_FFFF, 16'h0004, "R9 write misaligned");
    step(1, 10'h200, 32'hFFFF_FFFF, 16'h0004, "R9 write 0x200");
    readLit(10'h18, 32'h0, "R9 read 0x18");
    readLit(10'h3FC, 32'h0, "R9 read 0x3FC");
    readLit(10'h01, 32'h0, "R9 read misaligned");
    readAll("R9 registers unchanged");

    // Random phase
    for (int n = 0; n < 1500; n++) begin
      logic [9:0] a;
      logic [31:0] d;
      logic [15:0] e;
      int r;
      r = $urandom % 16;
      if (r < 12) a = 10'((r >= 6 ? 32 : 0) + (r % 6) * 4);
      else if (r == 12) a = 10'h18;
      else if (r == 13) a = 10'h3A;
      else a = 10'($urandom);
      d = ($urandom % 4 == 0) ? $urandom : ($urandom & $urandom);
      e = extIn;
      if ($urandom % 2 == 0) e = e ^ 16'($urandom & $urandom);
      step(($urandom % 3) != 0, a, d, e, "R4 R5 R6 R7 R8 random pulses");
      if (n % 5 == 0) readChk(10'(($urandom % 16) * 4), "R3 R9 random readback");
    end
    readAll("R2 R3 final registers");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule